// File: doc/BRIEF.md
# DMA Descriptor Loop Sequencer

This block runs one channel's transfer descriptor once that descriptor has been loaded. A start pulse captures the descriptor from the input pins. The descriptor holds the source and destination addresses, the signed per-access offsets, the access size codes, the circular-window sizes, the byte count of one inner (minor) loop and the number of outer (major) iterations. It also holds the end-of-run address corrections, an optional per-minor-loop offset, a stall code, a link mode with its target channel, and the interrupt and auto-stop enables.

After the start pulse the sequencer issues alternating read and write accesses. Each access has one strobe cycle that presents its current address. Once the minor byte count is used up, the iteration count drops by one. When the iteration count runs out, the addresses receive their end-of-run corrections, the beginning count is reloaded and the done flag rises. Bus handshaking, descriptor fetch and channel arbitration belong to neighbouring blocks.

Top module: `dma_loop_seq`

## Requirements
- R1: During and after a synchronous active-high reset the block is idle: busy, strobes, done, request-enable, pulse outputs, iteration count and remaining byte count are all 0.
- R2: A start pulse while idle captures the descriptor, and busy is high from the next cycle until the cycle after the last write of the final minor loop. Start pulses while busy are ignored and do not alter the running transfer.
- R3: Accesses run as read then write. After each read the source address adds the sign-extended 16-bit source offset, and after each write the destination address adds its own offset. rd_size_o and wr_size_o carry the size codes, where code k means 2^k bytes (codes 0 to 5).
- R4: A modulo code of 0 leaves the offset sum unchanged. A code n from 1 to 31 takes only the low n bits from the sum and keeps the upper bits of the old address.
- R5: minor_left_o starts at the programmed byte count and drops by the destination access size after every write. At the end of each minor loop it returns to the programmed value, and iter_o drops by one.
- R6: When an enable is set, the signed minor offset is added to the source or destination address at the end of every minor loop (each address has its own enable).
- R7: When the iteration count runs out, the last-address corrections are added to both addresses, iter_o reloads the beginning count, and done_o rises. done_o is cleared by the next accepted start.
- R8: Stall code 2 inserts 4 idle cycles after every access and code 3 inserts 8. Codes 0 and 1 insert none, and no stall follows the final write.
- R9: Link mode 1 gives a one-cycle link_req_o at every iteration decrement, and mode 2 only at exhaustion. Modes 0 and 3 give none. link_ch_o carries the programmed channel during the pulse.
- R10: With its enable set, half_irq_o pulses once when a non-final decrement leaves the count equal to the beginning count shifted right by one. major_irq_o pulses once at exhaustion when its enable is set.
- R11: req_en_o is set by an accepted start. It is cleared at exhaustion only when auto-stop is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, captures descriptor |
| src_addr_i | input | AW | Initial source address |
| dst_addr_i | input | AW | Initial destination address |
| src_off_i | input | OW | Signed source offset per read |
| dst_off_i | input | OW | Signed destination offset per write |
| src_size_i | input | 3 | Source size code |
| dst_size_i | input | 3 | Destination size code |
| src_mod_i | input | 5 | Source circular-window code |
| dst_mod_i | input | 5 | Destination circular-window code |
| minor_bytes_i | input | NW | Bytes per minor loop |
| iter_i | input | CW | Beginning iteration count |
| src_last_i | input | AW | Source correction at exhaustion |
| dst_last_i | input | AW | Destination correction at exhaustion |
| minor_off_i | input | AW | Signed per-minor-loop offset |
| minor_off_src_en_i | input | 1 | Apply minor offset to source |
| minor_off_dst_en_i | input | 1 | Apply minor offset to destination |
| stall_code_i | input | 2 | Stall code |
| link_mode_i | input | 2 | Link mode |
| link_ch_i | input | CHW | Link target channel |
| half_irq_en_i | input | 1 | Half interrupt enable |
| major_irq_en_i | input | 1 | Major interrupt enable |
| auto_stop_i | input | 1 | Clear request enable at exhaustion |
| busy_o | output | 1 | Descriptor executing |
| rd_strobe_o | output | 1 | Read access cycle |
| rd_addr_o | output | AW | Current source address |
| rd_size_o | output | 3 | Source size code |
| wr_strobe_o | output | 1 | Write access cycle |
| wr_addr_o | output | AW | Current destination address |
| wr_size_o | output | 3 | Destination size code |
| minor_left_o | output | NW | Remaining minor-loop bytes |
| iter_o | output | CW | Current iteration count |
| done_o | output | 1 | Major loop finished |
| half_irq_o | output | 1 | Half-count interrupt pulse |
| major_irq_o | output | 1 | Exhaustion interrupt pulse |
| link_req_o | output | 1 | Link request pulse |
| link_ch_o | output | CHW | Link target channel |
| req_en_o | output | 1 | Hardware request enable |

## Verification
The assertions assume every accepted descriptor has a non-zero minor byte count that is an exact multiple of the destination access size, and a non-zero beginning iteration count. Under that assumption the remaining byte count never reads zero while busy, and each minor loop ends exactly on a write. The stimulus table only contains such descriptors. The directed start-while-busy case changes the descriptor pins only while the block is running, so the captured copy stays valid.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_READ   = 3'd1,
    ST_RSTALL = 3'd2,
    ST_WRITE  = 3'd3,
    ST_WSTALL = 3'd4
  } seq_state_e;

  localparam logic [1:0] LINK_MINOR = 2'd1;
  localparam logic [1:0] LINK_MAJOR = 2'd2;

  // Stall length per access for each stall code.
  function automatic logic [3:0] stall_cycles(input logic [1:0] code);
    case (code)
      2'd2:    stall_cycles = 4'd4;
      2'd3:    stall_cycles = 4'd8;
      default: stall_cycles = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_step.sv
// Next address = base + sign-extended offset, confined to a 2^n window.
module dma_addr_step #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  input  logic [4:0]    mod_i,
  output logic [AW-1:0] next_o
);
  logic [AW-1:0] sum;
  logic [AW-1:0] mask;

  always_comb begin
    sum  = base_i + {{(AW-OW){off_i[OW-1]}}, off_i};
    mask = ({{(AW-1){1'b0}}, 1'b1} << mod_i) - {{(AW-1){1'b0}}, 1'b1};
    if (mod_i == 5'd0) next_o = sum;
    else               next_o = (base_i & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/dma_iter_ctrl.sv
// Current/beginning major iteration counters.
module dma_iter_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] begin_i,
  input  logic          dec_i,
  output logic [CW-1:0] citer_o,
  output logic          last_o,
  output logic          half_hit_o
);
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  logic [CW-1:0] citer_q;
  logic [CW-1:0] biter_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      citer_q <= '0;
      biter_q <= '0;
    end else if (load_i) begin
      citer_q <= begin_i;
      biter_q <= begin_i;
    end else if (dec_i) begin
      citer_q <= (citer_q == ONE) ? biter_q : citer_q - ONE;
    end
  end

  assign citer_o    = citer_q;
  assign last_o     = (citer_q == ONE);
  assign half_hit_o = ((citer_q - ONE) == (biter_q >> 1));
endmodule

// File: rtl/dma_stall_timer.sv
// Down-counter; expire_o marks the final stall cycle.
module dma_stall_timer #(
  parameter int SW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [SW-1:0] len_i,
  output logic          expire_o
);
  localparam logic [SW-1:0] ONE = {{(SW-1){1'b0}}, 1'b1};
  logic [SW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - ONE;
  end

  assign expire_o = (cnt_q == ONE);
endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq
  import dma_seq_pkg::*;
#(
  parameter int AW  = 32,
  parameter int OW  = 16,
  parameter int NW  = 32,
  parameter int CW  = 16,
  parameter int CHW = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic [AW-1:0]  src_addr_i,
  input  logic [AW-1:0]  dst_addr_i,
  input  logic [OW-1:0]  src_off_i,
  input  logic [OW-1:0]  dst_off_i,
  input  logic [2:0]     src_size_i,
  input  logic [2:0]     dst_size_i,
  input  logic [4:0]     src_mod_i,
  input  logic [4:0]     dst_mod_i,
  input  logic [NW-1:0]  minor_bytes_i,
  input  logic [CW-1:0]  iter_i,
  input  logic [AW-1:0]  src_last_i,
  input  logic [AW-1:0]  dst_last_i,
  input  logic [AW-1:0]  minor_off_i,
  input  logic           minor_off_src_en_i,
  input  logic           minor_off_dst_en_i,
  input  logic [1:0]     stall_code_i,
  input  logic [1:0]     link_mode_i,
  input  logic [CHW-1:0] link_ch_i,
  input  logic           half_irq_en_i,
  input  logic           major_irq_en_i,
  input  logic           auto_stop_i,
  output logic           busy_o,
  output logic           rd_strobe_o,
  output logic [AW-1:0]  rd_addr_o,
  output logic [2:0]     rd_size_o,
  output logic           wr_strobe_o,
  output logic [AW-1:0]  wr_addr_o,
  output logic [2:0]     wr_size_o,
  output logic [NW-1:0]  minor_left_o,
  output logic [CW-1:0]  iter_o,
  output logic           done_o,
  output logic           half_irq_o,
  output logic           major_irq_o,
  output logic           link_req_o,
  output logic [CHW-1:0] link_ch_o,
  output logic           req_en_o
);
  localparam int SW = 4;

  seq_state_e     state_q;
  logic [AW-1:0]  saddr_q, daddr_q, slast_q, dlast_q, mloff_q;
  logic [OW-1:0]  soff_q, doff_q;
  logic [2:0]     ssz_q, dsz_q;
  logic [4:0]     smod_q, dmod_q;
  logic [NW-1:0]  nbytes_q, minor_left_q;
  logic           mls_q, mld_q, hie_q, mie_q, ast_q;
  logic [SW-1:0]  stall_q;
  logic [1:0]     lmode_q;
  logic [CHW-1:0] lch_q;
  logic           done_q, half_q, major_q, link_q, reqen_q;

  logic [AW-1:0]  s_step, d_step, s_adj, d_adj;
  logic [NW-1:0]  dbytes;
  logic           accept, minor_end, exhaust, iter_last, half_hit;
  logic           stall_load, stall_exp, link_fire;
  logic [CW-1:0]  citer;

  dma_addr_step #(.AW(AW), .OW(OW)) u_src_step (
    .base_i(saddr_q), .off_i(soff_q), .mod_i(smod_q), .next_o(s_step));
  dma_addr_step #(.AW(AW), .OW(OW)) u_dst_step (
    .base_i(daddr_q), .off_i(doff_q), .mod_i(dmod_q), .next_o(d_step));

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign dbytes    = {{(NW-1){1'b0}}, 1'b1} << dsz_q;
  assign minor_end = (state_q == ST_WRITE) && (minor_left_q <= dbytes);
  assign exhaust   = minor_end && iter_last;
  assign link_fire = (lmode_q == LINK_MINOR) || ((lmode_q == LINK_MAJOR) && exhaust);
  assign s_adj     = (mls_q ? mloff_q : '0) + (exhaust ? slast_q : '0);
  assign d_adj     = (mld_q ? mloff_q : '0) + (exhaust ? dlast_q : '0);
  assign stall_load = (stall_q != '0) &&
                      ((state_q == ST_READ) || ((state_q == ST_WRITE) && !exhaust));

  dma_iter_ctrl #(.CW(CW)) u_iter (
    .clk(clk), .rst(rst), .load_i(accept), .begin_i(iter_i),
    .dec_i(minor_end), .citer_o(citer), .last_o(iter_last), .half_hit_o(half_hit));

  dma_stall_timer #(.SW(SW)) u_stall (
    .clk(clk), .rst(rst), .load_i(stall_load), .len_i(stall_q), .expire_o(stall_exp));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      saddr_q <= '0; daddr_q <= '0; slast_q <= '0; dlast_q <= '0; mloff_q <= '0;
      soff_q <= '0; doff_q <= '0; ssz_q <= '0; dsz_q <= '0; smod_q <= '0; dmod_q <= '0;
      nbytes_q <= '0; minor_left_q <= '0;
      mls_q <= 1'b0; mld_q <= 1'b0; hie_q <= 1'b0; mie_q <= 1'b0; ast_q <= 1'b0;
      stall_q <= '0; lmode_q <= '0; lch_q <= '0;
      done_q <= 1'b0; half_q <= 1'b0; major_q <= 1'b0; link_q <= 1'b0; reqen_q <= 1'b0;
    end else begin
      half_q  <= 1'b0;
      major_q <= 1'b0;
      link_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          saddr_q <= src_addr_i;   daddr_q <= dst_addr_i;
          soff_q  <= src_off_i;    doff_q  <= dst_off_i;
          ssz_q   <= src_size_i;   dsz_q   <= dst_size_i;
          smod_q  <= src_mod_i;    dmod_q  <= dst_mod_i;
          nbytes_q <= minor_bytes_i; minor_left_q <= minor_bytes_i;
          slast_q <= src_last_i;   dlast_q <= dst_last_i;  mloff_q <= minor_off_i;
          mls_q   <= minor_off_src_en_i; mld_q <= minor_off_dst_en_i;
          stall_q <= stall_cycles(stall_code_i);
          lmode_q <= link_mode_i;  lch_q   <= link_ch_i;
          hie_q   <= half_irq_en_i; mie_q  <= major_irq_en_i; ast_q <= auto_stop_i;
          done_q  <= 1'b0;
          reqen_q <= 1'b1;
          state_q <= ST_READ;
        end
        ST_READ: begin
          saddr_q <= s_step;
          state_q <= (stall_q != '0) ? ST_RSTALL : ST_WRITE;
        end
        ST_RSTALL: if (stall_exp) state_q <= ST_WRITE;
        ST_WRITE: begin
          if (minor_end) begin
            minor_left_q <= nbytes_q;
            saddr_q <= saddr_q + s_adj;
            daddr_q <= d_step + d_adj;
            link_q  <= link_fire;
          end else begin
            minor_left_q <= minor_left_q - dbytes;
            daddr_q <= d_step;
          end
          if (exhaust) begin
            done_q  <= 1'b1;
            major_q <= mie_q;
            if (ast_q) reqen_q <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            half_q  <= minor_end && hie_q && half_hit;
            state_q <= (stall_q != '0) ? ST_WSTALL : ST_READ;
          end
        end
        ST_WSTALL: if (stall_exp) state_q <= ST_READ;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign rd_strobe_o  = (state_q == ST_READ);
  assign wr_strobe_o  = (state_q == ST_WRITE);
  assign rd_addr_o    = saddr_q;
  assign wr_addr_o    = daddr_q;
  assign rd_size_o    = ssz_q;
  assign wr_size_o    = dsz_q;
  assign minor_left_o = minor_left_q;
  assign iter_o       = citer;
  assign done_o       = done_q;
  assign half_irq_o   = half_q;
  assign major_irq_o  = major_q;
  assign link_req_o   = link_q;
  assign link_ch_o    = lch_q;
  assign req_en_o     = reqen_q;
endmodule

// File: rtl/dma_loop_seq_chk.sv
module dma_loop_seq_chk #(
  parameter int NW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start_i,
  input logic          busy_o,
  input logic          rd_strobe_o,
  input logic          wr_strobe_o,
  input logic [NW-1:0] minor_left_o,
  input logic          done_o,
  input logic          major_irq_o,
  input logic          link_req_o,
  input logic          req_en_o
);
  p_busy_after_start_r2: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o);
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (!rd_strobe_o && !wr_strobe_o));
  p_rd_wr_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(rd_strobe_o && wr_strobe_o));
  p_minor_left_live_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (minor_left_o != '0));
  p_done_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> !done_o);
  p_done_at_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> done_o);
  p_link_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    link_req_o |=> !link_req_o);
  p_major_irq_r10: assert property (@(posedge clk) disable iff (rst)
    major_irq_o |-> (done_o && !busy_o));
  p_autostop_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(req_en_o) |-> $fell(busy_o));
endmodule

bind dma_loop_seq dma_loop_seq_chk #(.NW(NW)) u_chk (
  .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
  .rd_strobe_o(rd_strobe_o), .wr_strobe_o(wr_strobe_o),
  .minor_left_o(minor_left_o), .done_o(done_o), .major_irq_o(major_irq_o),
  .link_req_o(link_req_o), .req_en_o(req_en_o));

// File: tb/dma_loop_seq_tb_top.sv
module dma_loop_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [31:0] saddr; logic [31:0] daddr;
    logic [15:0] soff;  logic [15:0] doff;
    logic [2:0]  ssz;   logic [2:0]  dsz;
    logic [4:0]  smod;  logic [4:0]  dmod;
    logic [31:0] nbytes; logic [15:0] iter;
    logic [31:0] slast; logic [31:0] dlast; logic [31:0] mloff;
    logic mls; logic mld;
    logic [1:0] bwc; logic [1:0] lmode; logic [4:0] lch;
    logic hie; logic mie; logic ast;
    logic [31:0] exp_rd1; logic [31:0] exp_wr1;
    logic [31:0] exp_s;   logic [31:0] exp_d;
    logic [31:0] exp_busy; logic [7:0] exp_links; logic [7:0] exp_halfs;
  } vec_t;

  // Expected values worked out by hand from the requirements.
  localparam vec_t VECS [4] = '{
    // plain, end-of-run rewind, major link, half irq, auto-stop
    '{32'h1000, 32'h2000, 16'd4, 16'd4, 3'd2, 3'd2, 5'd0, 5'd0, 32'd8, 16'd2,
      32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'd0, 1'b0, 1'b0, 2'd0, 2'd2, 5'd3,
      1'b1, 1'b1, 1'b1, 32'h1004, 32'h2004, 32'h1000, 32'h2000, 32'd8, 8'd1, 8'd1},
    // source 16-byte window wrap, minor link, no auto-stop
    '{32'h100C, 32'h3000, 16'd4, 16'd4, 3'd2, 3'd2, 5'd4, 5'd0, 32'd16, 16'd1,
      32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 2'd0, 2'd1, 5'd7,
      1'b1, 1'b1, 1'b0, 32'h1000, 32'h3004, 32'h100C, 32'h3010, 32'd8, 8'd1, 8'd0},
    // minor offset on source, negative dst offset, 4-cycle stall
    '{32'h4000, 32'h5010, 16'd2, 16'hFFFE, 3'd1, 3'd1, 5'd0, 5'd0, 32'd4, 16'd3,
      32'd0, 32'h20, 32'h100, 1'b1, 1'b0, 2'd2, 2'd1, 5'd12,
      1'b1, 1'b1, 1'b1, 32'h4002, 32'h500E, 32'h430C, 32'h5024, 32'd56, 8'd3, 8'd1},
    // 8-byte beats, negative dst offset wrapping in 32-byte window, 8-cycle stall
    '{32'h7000, 32'h6000, 16'd8, 16'hFFF8, 3'd3, 3'd3, 5'd0, 5'd5, 32'd16, 16'd1,
      32'd0, 32'd0, 32'd0, 1'b0, 1'b0, 2'd3, 2'd0, 5'd0,
      1'b1, 1'b0, 1'b0, 32'h7008, 32'h6018, 32'h7010, 32'h6010, 32'd28, 8'd0, 8'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] src_addr_i = '0, dst_addr_i = '0;
  logic [15:0] src_off_i = '0, dst_off_i = '0;
  logic [2:0]  src_size_i = '0, dst_size_i = '0;
  logic [4:0]  src_mod_i = '0, dst_mod_i = '0;
  logic [31:0] minor_bytes_i = '0;
  logic [15:0] iter_i = '0;
  logic [31:0] src_last_i = '0, dst_last_i = '0, minor_off_i = '0;
  logic        minor_off_src_en_i = 1'b0, minor_off_dst_en_i = 1'b0;
  logic [1:0]  stall_code_i = '0, link_mode_i = '0;
  logic [4:0]  link_ch_i = '0;
  logic        half_irq_en_i = 1'b0, major_irq_en_i = 1'b0, auto_stop_i = 1'b0;

  logic        busy_o, rd_strobe_o, wr_strobe_o, done_o;
  logic        half_irq_o, major_irq_o, link_req_o, req_en_o;
  logic [31:0] rd_addr_o, wr_addr_o, minor_left_o;
  logic [2:0]  rd_size_o, wr_size_o;
  logic [15:0] iter_o;
  logic [4:0]  link_ch_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_loop_seq dut_i (
    .clk(clk), .rst(rst), .start_i(start_i),
    .src_addr_i(src_addr_i), .dst_addr_i(dst_addr_i),
    .src_off_i(src_off_i), .dst_off_i(dst_off_i),
    .src_size_i(src_size_i), .dst_size_i(dst_size_i),
    .src_mod_i(src_mod_i), .dst_mod_i(dst_mod_i),
    .minor_bytes_i(minor_bytes_i), .iter_i(iter_i),
    .src_last_i(src_last_i), .dst_last_i(dst_last_i), .minor_off_i(minor_off_i),
    .minor_off_src_en_i(minor_off_src_en_i), .minor_off_dst_en_i(minor_off_dst_en_i),
    .stall_code_i(stall_code_i), .link_mode_i(link_mode_i), .link_ch_i(link_ch_i),
    .half_irq_en_i(half_irq_en_i), .major_irq_en_i(major_irq_en_i),
    .auto_stop_i(auto_stop_i),
    .busy_o(busy_o), .rd_strobe_o(rd_strobe_o), .rd_addr_o(rd_addr_o),
    .rd_size_o(rd_size_o), .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o),
    .wr_size_o(wr_size_o), .minor_left_o(minor_left_o), .iter_o(iter_o),
    .done_o(done_o), .half_irq_o(half_irq_o), .major_irq_o(major_irq_o),
    .link_req_o(link_req_o), .link_ch_o(link_ch_o), .req_en_o(req_en_o));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset_state(input string tag);
    chk(busy_o == 1'b0 && rd_strobe_o == 1'b0 && wr_strobe_o == 1'b0,
        {tag, " R1 busy/strobes"}, {busy_o, rd_strobe_o, wr_strobe_o}, 0);
    chk(done_o == 1'b0 && req_en_o == 1'b0, {tag, " R1 done/req_en"},
        {done_o, req_en_o}, 0);
    chk(link_req_o == 1'b0 && half_irq_o == 1'b0 && major_irq_o == 1'b0,
        {tag, " R1 pulses"}, {link_req_o, half_irq_o, major_irq_o}, 0);
    chk(iter_o == 16'd0 && minor_left_o == 32'd0, {tag, " R1 counters"},
        {iter_o, minor_left_o}, 0);
  endtask

  task automatic apply(input vec_t v);
    src_addr_i = v.saddr;  dst_addr_i = v.daddr;
    src_off_i = v.soff;    dst_off_i = v.doff;
    src_size_i = v.ssz;    dst_size_i = v.dsz;
    src_mod_i = v.smod;    dst_mod_i = v.dmod;
    minor_bytes_i = v.nbytes; iter_i = v.iter;
    src_last_i = v.slast;  dst_last_i = v.dlast; minor_off_i = v.mloff;
    minor_off_src_en_i = v.mls; minor_off_dst_en_i = v.mld;
    stall_code_i = v.bwc;  link_mode_i = v.lmode; link_ch_i = v.lch;
    half_irq_en_i = v.hie; major_irq_en_i = v.mie; auto_stop_i = v.ast;
  endtask

  task automatic run_vec(input vec_t v, input int poke, input string tag);
    int busy_n, rd_n, wr_n, links, halfs, majors, bad_ch, bad_sz;
    logic [31:0] rd1, wr1, ml1;
    busy_n = 0; rd_n = 0; wr_n = 0; links = 0; halfs = 0; majors = 0;
    bad_ch = 0; bad_sz = 0; rd1 = '0; wr1 = '0; ml1 = '0;
    apply(v);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      if (k == 0) chk(done_o == 1'b0, {tag, " R7 done cleared by start"}, done_o, 0);
      if (rd_strobe_o) begin
        if (rd_n == 1) rd1 = rd_addr_o;
        if (rd_size_o != v.ssz) bad_sz++;
        rd_n++;
      end
      if (wr_strobe_o) begin
        if (wr_n == 1) begin wr1 = wr_addr_o; ml1 = minor_left_o; end
        if (wr_size_o != v.dsz) bad_sz++;
        wr_n++;
      end
      if (link_req_o) begin
        links++;
        if (link_ch_o != v.lch) bad_ch++;
      end
      if (half_irq_o) halfs++;
      if (major_irq_o) majors++;
      if (!busy_o) break;
      busy_n++;
      if (k == poke) begin
        start_i = 1'b1; src_addr_i = 32'hDEAD_0000; iter_i = 16'd9;
      end else if (k == poke + 1) begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    chk(rd1 == v.exp_rd1, {tag, " R3 R4 second read address"}, rd1, v.exp_rd1);
    chk(wr1 == v.exp_wr1, {tag, " R3 R4 second write address"}, wr1, v.exp_wr1);
    chk(bad_sz == 0, {tag, " R3 size codes"}, bad_sz, 0);
    chk(ml1 == v.nbytes - (32'd1 << v.dsz), {tag, " R5 bytes left at second write"},
        ml1, v.nbytes - (32'd1 << v.dsz));
    chk(rd_addr_o == v.exp_s, {tag, " R6 R7 final source address"}, rd_addr_o, v.exp_s);
    chk(wr_addr_o == v.exp_d, {tag, " R6 R7 final destination address"}, wr_addr_o, v.exp_d);
    chk(busy_n == int'(v.exp_busy), {tag, " R2 R8 busy cycles"}, busy_n, v.exp_busy);
    chk(links == int'(v.exp_links), {tag, " R9 link pulses"}, links, v.exp_links);
    chk(bad_ch == 0, {tag, " R9 link channel"}, bad_ch, 0);
    chk(halfs == int'(v.exp_halfs), {tag, " R10 half pulses"}, halfs, v.exp_halfs);
    chk(majors == int'(v.mie), {tag, " R10 major pulses"}, majors, v.mie);
    chk(iter_o == v.iter, {tag, " R7 iteration reload"}, iter_o, v.iter);
    chk(done_o == 1'b1, {tag, " R7 done"}, done_o, 1);
    chk(req_en_o == !v.ast, {tag, " R11 request enable"}, req_en_o, !v.ast);
    chk(minor_left_o == v.nbytes, {tag, " R5 byte count restored"}, minor_left_o, v.nbytes);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state("reset");
    rst = 1'b0;
    @(negedge clk);
    check_reset_state("idle after reset");

    for (int i = 0; i < 4; i++) run_vec(VECS[i], -10, $sformatf("vec%0d", i));

    // R2: start pulse and changed pins while busy must not disturb the run.
    run_vec(VECS[0], 2, "start while busy R2");

    // R1: reset in the middle of a long stalled run.
    apply(VECS[2]);
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (7) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state("mid-run reset");
    rst = 1'b0;
    @(negedge clk);

    // After reset the block accepts a fresh descriptor.
    run_vec(VECS[1], -10, "after reset");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule